// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This core executes a small load/store instruction subset and retires exactly one instruction on every clock edge. In each cycle the current program counter drives the instruction port. The fetched word is decoded, two operands are read combinationally from a 32-entry register file, and the ALU result and the next program counter are formed. Every state change is then committed at the next rising edge: the register write, the data-memory write and the program counter update.

The instruction memory and the data memory sit outside the core. Both are plain arrays that return read data combinationally from the address and accept writes on the rising edge. They are word-addressed with address bits [7:2] in the bench. No alignment check is made. The program counter's reset value is a parameter. Register contents are not cleared by reset.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, imem_addr_o equals the PC_RESET parameter and dmem_we_o is 0. The first instruction after release is fetched from PC_RESET.
- R2: Opcode 0x00 writes register rd (bits [15:11]) with the result of an operation chosen by funct (bits [5:0]), using rs (bits [25:21]) and rt (bits [20:16]) as operands. The funct codes are: 0x20 add, 0x22 subtract, 0x24 bitwise and, 0x25 bitwise or, 0x2A signed less-than giving 1 or 0.
- R3: Opcode 0x08 writes rt with rs plus the sign-extended 16-bit immediate in bits [15:0].
- R4: Opcode 0x23 drives dmem_addr_o with rs plus the sign-extended offset and writes dmem_rdata_i into rt at the same edge.
- R5: Opcode 0x2B asserts dmem_we_o for exactly that cycle, with dmem_addr_o equal to rs plus the sign-extended offset and dmem_wdata_o equal to rt. No register is written.
- R6: Opcode 0x04 compares rs with rt. If they are equal, the next PC is PC+4 plus the sign-extended offset times 4; otherwise it is PC+4. Backward offsets are included.
- R7: Opcode 0x02 sets the next PC to {PC[31:28], bits [25:0], 2'b00}.
- R8: Register 0 always reads as zero. Writes aimed at it have no effect.
- R9: Every instruction takes one cycle. A non-control instruction advances the PC by 4, and a value written by one instruction is the operand seen by the next.
- R10: An undefined opcode, or opcode 0x00 with an undefined funct, writes neither a register nor memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data_i | input | 32 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Data byte address (ALU result) |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store strobe, committed at the rising edge |
| dmem_rdata_i | input | 32 | Load data at dmem_addr_o |

## Verification
The register file is only visible through stores and branches, so a corrupted register shows up late. It appears at the ports the next time that register feeds dmem_addr_o or dmem_wdata_o, or steers a branch. A reference model steps alongside the core and compares the PC and every store each cycle. A wrong next-PC computation is therefore reported in the very next cycle, while a bad register write is reported at its first use. Final memory contents then confirm skipped paths and ignored writes.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    src_imm;
    logic    mem_to_reg;
    logic    mem_we;
    logic    is_branch;
    logic    is_jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_op = ALU_ADD;
    case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.reg_we = 1'b1;
        case (funct_i)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o.reg_we = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.src_imm = 1'b1;
      end
      OP_LW: begin
        ctrl_o.reg_we     = 1'b1;
        ctrl_o.src_imm    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
      end
      OP_SW: begin
        ctrl_o.mem_we  = 1'b1;
        ctrl_o.src_imm = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.is_branch = 1'b1;
        ctrl_o.alu_op    = ALU_SUB;
      end
      OP_J:    ctrl_o.is_jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = '0;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i) begin
    if (we_i && wa_i != '0) regs_q[wa_i] <= wd_i;
  end

  assign rd1_o = (ra1_i == '0) ? '0 : regs_q[ra1_i];
  assign rd2_o = (ra2_i == '0) ? '0 : regs_q[ra2_i];

  // last write is what the next read of that register sees
  p_wr_then_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i) && $past(wa_i) != '0 && ra1_i == $past(wa_i) |-> rd1_o == $past(wd_i));

  p_zero_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i) && $past(wa_i) == '0 && ra2_i == '0 |-> rd2_o == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter logic [31:0] PC_RESET = 32'h0000_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [31:0] imem_addr_o,
  input  logic [31:0] imem_data_i,
  output logic [31:0] dmem_addr_o,
  output logic [31:0] dmem_wdata_o,
  output logic        dmem_we_o,
  input  logic [31:0] dmem_rdata_i
);
  localparam int AW = $clog2(NREG);

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_tgt, j_tgt;
  logic [XLEN-1:0] instr, imm_sx, rd1, rd2, alu_b, alu_y, wb_data;
  logic [AW-1:0]   rs, rt, rd, wa;
  logic            alu_zero, rf_we, take_br;
  ctrl_t           ctrl;

  assign instr = imem_data_i;
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign imm_sx = {{16{instr[15]}}, instr[15:0]};

  sc_decode u_dec (
    .opcode_i (instr[31:26]),
    .funct_i  (instr[5:0]),
    .ctrl_o   (ctrl)
  );

  assign wa    = ctrl.dst_rd ? rd : rt;
  assign rf_we = ctrl.reg_we & rst_ni;

  sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (rs),
    .ra2_i  (rt),
    .rd1_o  (rd1),
    .rd2_o  (rd2),
    .we_i   (rf_we),
    .wa_i   (wa),
    .wd_i   (wb_data)
  );

  assign alu_b = ctrl.src_imm ? imm_sx : rd2;

  sc_alu #(.W(XLEN)) u_alu (
    .a_i    (rd1),
    .b_i    (alu_b),
    .op_i   (ctrl.alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  assign wb_data = ctrl.mem_to_reg ? dmem_rdata_i : alu_y;

  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rd2;
  assign dmem_we_o    = ctrl.mem_we & rst_ni;

  // next PC formed in the same pass as the data result
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + (imm_sx << 2);
  assign j_tgt    = {pc_q[31:28], instr[25:0], 2'b00};
  assign take_br  = ctrl.is_branch & alu_zero;

  always_comb begin
    if (ctrl.is_jump)   pc_next = j_tgt;
    else if (take_br)   pc_next = br_tgt;
    else                pc_next = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= PC_RESET;
    else         pc_q <= pc_next;
  end

  assign imem_addr_o = pc_q;

  p_pc_aligned_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q[1:0] == 2'b00);

  p_seq_pc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(ctrl.is_jump) && !$past(ctrl.is_branch)
      |-> pc_q == $past(pc_q) + 32'd4);

  p_beq_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(ctrl.is_branch) && $past(rd1) == $past(rd2)
      |-> pc_q == $past(pc_q) + 32'd4 + ($past(imm_sx) << 2));

  p_beq_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(ctrl.is_branch) && $past(rd1) != $past(rd2)
      |-> pc_q == $past(pc_q) + 32'd4);

  p_jump_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(ctrl.is_jump)
      |-> pc_q == {$past(pc_q[31:28]), $past(instr[25:0]), 2'b00});

  p_store_no_wb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dmem_we_o, rf_we}));
endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
  localparam logic [31:0] RST_PC = 32'h0000_0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] mdm  [64];
  logic [31:0] mreg [32];
  logic [31:0] mpc;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sc_core #(.PC_RESET(RST_PC)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .imem_addr_o  (imem_addr),
    .imem_data_i  (imem_data),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .dmem_we_o    (dmem_we),
    .dmem_rdata_i (dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] r_ins(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference: compare this cycle's ports, then advance
  task automatic model_step();
    logic [31:0] ins, a, b, sx, res;
    logic [5:0]  op, fn;
    int          rs, rt, dst;
    bit          wr, st;
    logic [31:0] npc;
    ins = imem[mpc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]);
    a = mreg[rs]; b = mreg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    npc = mpc + 4; wr = 0; st = 0; res = 0; dst = rt;
    case (op)
      6'h00: begin
        dst = int'(ins[15:11]); wr = 1;
        case (fn)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: wr = 0;
        endcase
      end
      6'h08: begin wr = 1; res = a + sx; end
      6'h23: begin wr = 1; res = mdm[(a + sx) >> 2 & 63]; end
      6'h2B: st = 1;
      6'h04: if (a == b) npc = mpc + 4 + (sx << 2);
      6'h02: npc = {mpc[31:28], ins[25:0], 2'b00};
      default: ;
    endcase
    chk("R9 pc", imem_addr, mpc);
    chk("R5 store strobe", {31'd0, dmem_we}, {31'd0, st});
    if (st) begin
      chk("R5 store addr", dmem_addr, a + sx);
      chk("R5 store data", dmem_wdata, b);
      mdm[(a + sx) >> 2 & 63] = b;
    end
    if (op == 6'h23) chk("R4 load addr", dmem_addr, a + sx);
    if (wr && dst != 0) mreg[dst] = res;
    mpc = npc;
  endtask

  initial begin
    #(5.0 * 20000);
    checks++; errors++;
    $display("FAIL watchdog R9 actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'hDEAD_0000 + 32'(i);
    end
    dmem[39] = 32'h1234_5678;
    for (int i = 0; i < 64; i++) mdm[i] = dmem[i];
    for (int i = 0; i < 32; i++) mreg[i] = 32'h0;

    imem[4]  = i_ins(6'h08, 0, 1, 5);
    imem[5]  = i_ins(6'h08, 0, 2, -3);
    imem[6]  = r_ins(1, 2, 3, 6'h20);
    imem[7]  = r_ins(1, 2, 4, 6'h22);
    imem[8]  = r_ins(1, 2, 5, 6'h24);
    imem[9]  = r_ins(1, 2, 6, 6'h25);
    imem[10] = r_ins(2, 1, 7, 6'h2A);
    imem[11] = i_ins(6'h08, 1, 0, 7);
    imem[12] = i_ins(6'h2B, 0, 0, 'h80);
    imem[13] = i_ins(6'h2B, 0, 3, 'h84);
    imem[14] = i_ins(6'h2B, 0, 4, 'h88);
    imem[15] = i_ins(6'h2B, 0, 5, 'h8C);
    imem[16] = i_ins(6'h2B, 0, 6, 'h90);
    imem[17] = i_ins(6'h2B, 0, 7, 'h94);
    imem[18] = i_ins(6'h08, 0, 8, 'hA0);
    imem[19] = i_ins(6'h23, 8, 9, -4);
    imem[20] = r_ins(9, 9, 10, 6'h20);
    imem[21] = i_ins(6'h2B, 8, 10, 4);
    imem[22] = i_ins(6'h04, 1, 2, 5);
    imem[23] = i_ins(6'h04, 3, 3, 2);
    imem[24] = i_ins(6'h08, 0, 11, 99);
    imem[25] = i_ins(6'h2B, 8, 11, 8);
    imem[26] = i_ins(6'h3F, 1, 3, 'h10);
    imem[27] = r_ins(1, 1, 3, 6'h3F);
    imem[28] = i_ins(6'h2B, 8, 3, 'hC);
    imem[29] = {6'h02, 26'd32};
    imem[30] = i_ins(6'h2B, 8, 1, 'h10);
    imem[32] = i_ins(6'h2B, 8, 1, 'h14);
    imem[33] = i_ins(6'h04, 0, 0, -1);

    repeat (3) @(negedge clk);
    chk("R1 pc in reset", imem_addr, RST_PC);
    chk("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
    rst_n = 1'b1;
    mpc = RST_PC;
    repeat (40) begin
      model_step();
      @(negedge clk);
    end

    chk("R8 r0 stays zero", dmem[32], 32'h0);
    chk("R2 add", dmem[33], 32'd2);
    chk("R2 sub", dmem[34], 32'd8);
    chk("R2 and", dmem[35], 32'd5);
    chk("R3 sign-extended imm via or", dmem[36], 32'hFFFF_FFFD);
    chk("R2 slt signed", dmem[37], 32'd1);
    chk("R4 load then add", dmem[41], 32'h2468_ACF0);
    chk("R6 skipped store", dmem[42], 32'hDEAD_002A);
    chk("R10 undefined ops", dmem[43], 32'd2);
    chk("R7 jumped-over store", dmem[44], 32'hDEAD_002C);
    chk("R7 jump target store", dmem[45], 32'd5);
    chk("R6 backward branch holds pc", imem_addr, 32'h0000_0084);
    for (int i = 0; i < 64; i++) chk("R9 model memory", dmem[i], mdm[i]);

    rst_n = 1'b0;
    #1;
    chk("R1 pc after reassert", imem_addr, RST_PC);
    chk("R1 no store after reassert", {31'd0, dmem_we}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule